// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Front End

This block sits between a host register bus and four 12-bit digital-to-analog converters. For each channel it holds a code register that the host writes. It also holds a shared range register with one bipolar select and one gain select per channel, and a control register with a converter enable bit and a buffered-mode bit. The converters and their amplifiers are outside the block. It drives only the codes and the range selects they consume.

In unbuffered mode a code write reaches its converter one clock later. In buffered mode code writes only fill a staging register per channel. A host read of the control register then moves all four staged codes to the converters in the same cycle, so the channels change together. Range settings are always staged. They take effect when the host reads the range register. While the enable bit is clear, every converter is held at the mid-scale code. Reads carry no data. Their only effect is the commit.

Top module: `dacbuf_quad`

## Requirements
- R1: After reset, the enable and buffered-mode bits, all staged and live codes, and all range selects are zero, so every code output shows mid-scale 0x800.
- R2: Bit 1 of the control register at offset 0x02 enables the converters; while it is 0 every code output is 0x800 whatever the live codes hold.
- R3: With bit 0 of the control register clear (unbuffered), a write to offset 0x14 + 2n sets code output n on the clock edge that captures the write.
- R4: With bit 0 of the control register set (buffered), a code write changes no code output.
- R5: A host read of offset 0x02 copies all staged codes to the live codes in one clock edge.
- R6: A write to the range register at offset 0x12 stages channel n's bipolar select from bit 7-n and its gain select from bit 11-n, and changes no range output.
- R7: A host read of offset 0x12 applies all staged range selects to the outputs in one clock edge.
- R8: Only bits 11:0 of a code write are kept, and bits 15:12 are ignored.
- R9: Writes to odd addresses or unmapped offsets, and reads of offsets other than 0x02 and 0x12, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (side effects only) |
| host_addr | input | 8 | Byte offset of the access |
| host_wdata | input | 16 | Write data |
| dac_code_o | output | 48 | Four converter codes, channel 0 in bits 11:0 |
| dac_bip_o | output | 4 | Bipolar select, bit n for channel n |
| dac_gain_o | output | 4 | Gain select, bit n for channel n |

## Verification
Every result of this block is due one clock edge after the access that causes it. A code write in unbuffered mode, a commit read, a range apply read and a control write all land on the edge that samples the strobe, because the code mux behind the enable register adds no delay. The bench drives each access on a falling edge, holds it across exactly one rising edge, and compares the outputs on the next falling edge. For accesses that must not change anything, the same sample point confirms that the outputs kept their previous values.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

   // register byte offsets; channel n code register at DATA0 + 2n
   localparam int unsigned OFS_CTRL  = 'h02;
   localparam int unsigned OFS_RANGE = 'h12;
   localparam int unsigned OFS_DATA0 = 'h14;
   localparam int unsigned DATA_STEP = 2;

   // control register fields
   localparam int unsigned BIT_BUFFERED = 0;
   localparam int unsigned BIT_ENABLE   = 1;

   // range register layout: highest bit belongs to channel 0
   localparam int unsigned BIP_TOP  = 7;
   localparam int unsigned GAIN_TOP = 11;
   localparam int unsigned MAX_CH   = 4;

   typedef struct packed {
      logic wr_ctrl;
      logic rd_ctrl;
      logic wr_range;
      logic rd_range;
   } strobe_t;

endpackage

// File: rtl/dacbuf_decode.sv
module dacbuf_decode
   import dacbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NUM_CH = 4
) (
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   output strobe_t           strb_o,
   output logic [NUM_CH-1:0] data_wr_o
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("dacbuf_decode: ADDR_W too small for the register map");
   end

   always_comb begin
      strb_o.wr_ctrl  = host_wr && (host_addr == A_CTRL);
      strb_o.rd_ctrl  = host_rd && (host_addr == A_CTRL);
      strb_o.wr_range = host_wr && (host_addr == A_RANGE);
      strb_o.rd_range = host_rd && (host_addr == A_RANGE);
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_data_dec
      localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA0 + DATA_STEP * i);
      assign data_wr_o[i] = host_wr && (host_addr == A_DATA);
   end

endmodule

// File: rtl/dacbuf_channel.sv
module dacbuf_channel #(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              buffered_i,
   input  logic              commit_i,
   input  logic [CODE_W-1:0] wdata_i,
   output logic [CODE_W-1:0] live_o
);

   logic [CODE_W-1:0] staged_q;
   logic [CODE_W-1:0] live_q;
   logic              load_now;

   assign load_now = wr_i && !buffered_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
         live_q   <= '0;
      end else begin
         if (wr_i) begin
            staged_q <= wdata_i;
         end
         if (load_now) begin
            live_q <= wdata_i;
         end else if (commit_i) begin
            live_q <= staged_q;
         end
      end
   end

   assign live_o = live_q;

   AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> (live_o == $past(wdata_i)));  // R3

   AST_BUFFERED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (buffered_i && !commit_i) |=> $stable(live_o));  // R4

   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !load_now) |=> (live_o == $past(staged_q)));  // R5

endmodule

// File: rtl/dacbuf_range.sv
module dacbuf_range
   import dacbuf_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              apply_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NUM_CH-1:0] bip_o,
   output logic [NUM_CH-1:0] gain_o
);

   if (NUM_CH > MAX_CH || NUM_CH == 0) begin : g_bad_ch
      $error("dacbuf_range: NUM_CH must be 1 to 4");
   end
   if (DATA_W <= GAIN_TOP) begin : g_bad_dw
      $error("dacbuf_range: DATA_W too narrow for the range register");
   end

   logic [NUM_CH-1:0] bip_stg_q, gain_stg_q;
   logic [NUM_CH-1:0] bip_q, gain_q;
   logic [NUM_CH-1:0] bip_field, gain_field;

   // channel order runs downward from the top bit of each field
   for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
      assign bip_field[i]  = wdata_i[BIP_TOP - i];
      assign gain_field[i] = wdata_i[GAIN_TOP - i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bip_stg_q  <= '0;
         gain_stg_q <= '0;
         bip_q      <= '0;
         gain_q     <= '0;
      end else begin
         if (wr_i) begin
            bip_stg_q  <= bip_field;
            gain_stg_q <= gain_field;
         end
         if (apply_i) begin
            bip_q  <= bip_stg_q;
            gain_q <= gain_stg_q;
         end
      end
   end

   assign bip_o  = bip_q;
   assign gain_o = gain_q;

   AST_RANGE_STAGED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> ($stable(bip_o) && $stable(gain_o)));  // R6

   AST_RANGE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      apply_i |=> ((bip_o == $past(bip_stg_q)) && (gain_o == $past(gain_stg_q))));  // R7

endmodule

// File: rtl/dacbuf_quad.sv
module dacbuf_quad
   import dacbuf_pkg::*;
#(
   parameter int unsigned NUM_CH        = 4,
   parameter int unsigned CODE_W        = 12,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned ADDR_W        = 8,
   parameter bit          IDLE_MIDSCALE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_wr,
   input  logic                     host_rd,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        dac_bip_o,
   output logic [NUM_CH-1:0]        dac_gain_o
);

   if (CODE_W > DATA_W || CODE_W < 2) begin : g_bad_code
      $error("dacbuf_quad: CODE_W must be 2 to DATA_W");
   end

   localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] IDLE_CODE = IDLE_MIDSCALE ? MID_CODE : '0;

   strobe_t           strb;
   logic [NUM_CH-1:0] data_wr;
   logic              enable_q, buffered_q;

   dacbuf_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .host_addr (host_addr),
      .strb_o    (strb),
      .data_wr_o (data_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q   <= 1'b0;
         buffered_q <= 1'b0;
      end else if (strb.wr_ctrl) begin
         enable_q   <= host_wdata[BIT_ENABLE];
         buffered_q <= host_wdata[BIT_BUFFERED];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CODE_W-1:0] live;

      dacbuf_channel #(.CODE_W(CODE_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (data_wr[i]),
         .buffered_i (buffered_q),
         .commit_i   (strb.rd_ctrl),
         .wdata_i    (host_wdata[CODE_W-1:0]),
         .live_o     (live)
      );

      assign dac_code_o[i*CODE_W +: CODE_W] = enable_q ? live : IDLE_CODE;
   end

   dacbuf_range #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_range (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (strb.wr_range),
      .apply_i (strb.rd_range),
      .wdata_i (host_wdata),
      .bip_o   (dac_bip_o),
      .gain_o  (dac_gain_o)
   );

   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wr_ctrl && !host_wdata[BIT_ENABLE]) |=> (dac_code_o == {NUM_CH{IDLE_CODE}}));  // R2

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(data_wr) <= 1);  // R9

endmodule

// File: tb/dacbuf_quad_tb.sv
`timescale 1ns/1ps
module dacbuf_quad_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [47:0] dac_code_o;
   logic [3:0]  dac_bip_o;
   logic [3:0]  dac_gain_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dacbuf_quad dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .dac_code_o (dac_code_o),
      .dac_bip_o  (dac_bip_o),
      .dac_gain_o (dac_gain_o)
   );

   typedef struct packed {
      logic [1:0]  op;    // 0 idle, 1 write, 2 read
      logic [7:0]  addr;
      logic [15:0] data;
      logic [47:0] code;  // {ch3, ch2, ch1, ch0}
      logic [3:0]  bip;
      logic [3:0]  gain;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h00, 16'h0000, 48'h800_800_800_800, 4'h0, 4'h0, 4'd1}, // R1 reset state
      '{2'd1, 8'h14, 16'h0123, 48'h800_800_800_800, 4'h0, 4'h0, 4'd2}, // R2 disabled
      '{2'd1, 8'h02, 16'h0002, 48'h000_000_000_123, 4'h0, 4'h0, 4'd2}, // R2 enable
      '{2'd1, 8'h16, 16'hF456, 48'h000_000_456_123, 4'h0, 4'h0, 4'd8}, // R8 top bits dropped
      '{2'd1, 8'h1A, 16'h0FFF, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd3}, // R3 direct load
      '{2'd1, 8'h15, 16'h0AAA, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd9}, // R9 odd address
      '{2'd1, 8'h02, 16'h0003, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd4}, // R4 buffered on
      '{2'd1, 8'h18, 16'h0789, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd4}, // R4 staged only
      '{2'd1, 8'h14, 16'h0111, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd4}, // R4 staged only
      '{2'd2, 8'h04, 16'h0000, 48'hFFF_000_456_123, 4'h0, 4'h0, 4'd9}, // R9 other read
      '{2'd2, 8'h02, 16'h0000, 48'hFFF_789_456_111, 4'h0, 4'h0, 4'd5}, // R5 commit
      '{2'd1, 8'h12, 16'h0A50, 48'hFFF_789_456_111, 4'h0, 4'h0, 4'd6}, // R6 range staged
      '{2'd2, 8'h12, 16'h0000, 48'hFFF_789_456_111, 4'hA, 4'h5, 4'd7}, // R7 range applied
      '{2'd1, 8'h02, 16'h0001, 48'h800_800_800_800, 4'hA, 4'h5, 4'd2}, // R2 disabled again
      '{2'd1, 8'h02, 16'h0002, 48'hFFF_789_456_111, 4'hA, 4'h5, 4'd3}, // R3 unbuffered
      '{2'd1, 8'h1A, 16'h1ABC, 48'hABC_789_456_111, 4'hA, 4'h5, 4'd3}  // R3 / R8
   };

   task automatic check(input int req, input logic [47:0] ecode,
                        input logic [3:0] ebip, input logic [3:0] egain);
      total++;
      if (dac_code_o !== ecode || dac_bip_o !== ebip || dac_gain_o !== egain) begin
         bad++;
         $display("FAIL R%0d code=%h bip=%h gain=%h expected code=%h bip=%h gain=%h",
                  req, dac_code_o, dac_bip_o, dac_gain_o, ecode, ebip, egain);
      end
   endtask

   // drive on a falling edge, hold over one rising edge, sample on next falling edge
   task automatic access(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] data);
      @(negedge clk);
      host_wr    = (op == 2'd1);
      host_rd    = (op == 2'd2);
      host_addr  = addr;
      host_wdata = data;
      @(negedge clk);
      host_wr    = 1'b0;
      host_rd    = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, 48'h800_800_800_800, 4'h0, 4'h0);  // R1 in reset
      rst_n = 1'b1;
      for (int v = 0; v < NV; v++) begin
         access(VECS[v].op, VECS[v].addr, VECS[v].data);
         check(int'(VECS[v].req), VECS[v].code, VECS[v].bip, VECS[v].gain);
      end

      // R5: commit read in unbuffered mode leaves live codes as written
      access(2'd2, 8'h02, 16'h0000);
      check(5, 48'hABC_789_456_111, 4'hA, 4'h5);

      // R9: write beyond the last channel changes nothing
      access(2'd1, 8'h1C, 16'h0555);
      check(9, 48'hABC_789_456_111, 4'hA, 4'h5);

      // R6: rewriting range register leaves applied selects alone
      access(2'd1, 8'h12, 16'h0000);
      check(6, 48'hABC_789_456_111, 4'hA, 4'h5);

      // R5: buffered write then commit moves only that staged code
      access(2'd1, 8'h02, 16'h0003);
      access(2'd1, 8'h16, 16'h0321);
      check(4, 48'hABC_789_456_111, 4'hA, 4'h5);
      access(2'd2, 8'h02, 16'h0000);
      check(5, 48'hABC_789_321_111, 4'hA, 4'h5);

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, 48'h800_800_800_800, 4'h0, 4'h0);
      rst_n = 1'b1;
      access(2'd1, 8'h02, 16'h0002);
      check(1, 48'h000_000_000_000, 4'h0, 4'h0);  // R1 live codes zeroed
      access(2'd2, 8'h12, 16'h0000);
      check(1, 48'h000_000_000_000, 4'h0, 4'h0);  // R1 staged range zeroed

      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule